// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block performs 32-bit integer multiply and divide for a simple in-order core and owns the two result registers, HI and LO, that hold the results. A command is issued with a one-cycle start pulse carrying a 6-bit function code and two operands, `rs_val` and `rt_val`.

A multiply forms the full 64-bit product in the cycle it is issued. A divide runs a restoring algorithm that produces one quotient bit per cycle, and the unit reports it as busy until the quotient and remainder are stored. Moves into HI or LO write one register directly from `rs_val`. Moves out of HI or LO use a separate read port. That port holds its valid flag low while a divide is in flight, so the core's interlock only needs to wait on that flag.

Top module: `hilo_unit`

## Requirements
- R1: After reset, HI and LO are 0 and `busy` is low.
- R2: Code 24 (signed multiply) writes the low half of the signed 64-bit product `rs_val*rt_val` to LO and the high half to HI on the issuing clock edge. `busy` does not rise.
- R3: Code 25 (unsigned multiply) does the same with both operands treated as unsigned. For 0x12345678 and 0xabcdef01 the HI of code 24 differs from the HI of code 25.
- R4: Code 26 (signed divide, `rs_val` by `rt_val`) puts the quotient, truncated toward zero, in LO and the remainder, with the dividend's sign, in HI. 0x80000000 divided by -1 gives LO=0x80000000 and HI=0.
- R5: Code 27 (unsigned divide) puts the unsigned quotient in LO and the remainder in HI.
- R6: After a divide is accepted, `busy` is high for exactly 32 cycles. HI and LO stay unchanged while it is high, and the result appears when it falls.
- R7: Code 17 writes `rs_val` to HI only, and code 19 writes `rs_val` to LO only. Each takes effect on the issuing edge.
- R8: With `rd_req` high, `rd_data` returns HI when `rd_hi`=1 and LO when `rd_hi`=0. `rd_valid` is `rd_req` while idle and is low throughout a busy period.
- R9: A start pulse of any code while `busy` is high is ignored.
- R10: Any code other than 17, 19, 24, 25, 26 and 27 on a start pulse leaves HI and LO unchanged. This includes 16 and 18, the read codes served by the read port.
- R11: A divide by zero, signed or unsigned, completes in the same 32 cycles and returns the unit to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle command strobe |
| funct | input | 6 | Function code of the command |
| rs_val | input | 32 | First operand: multiplicand, dividend, or move source |
| rt_val | input | 32 | Second operand: multiplier or divisor |
| busy | output | 1 | Divide in progress |
| rd_req | input | 1 | Read request |
| rd_hi | input | 1 | Read select: 1 for HI, 0 for LO |
| rd_valid | output | 1 | Read data is valid |
| rd_data | output | 32 | HI or LO contents |

## Verification
The hardest situation to reach from the ports is a command that arrives in the middle of a divide. The pending result must win, and the stray command must leave no trace once the divide retires. The bench issues a divide, tries a read while `busy` is high, then fires a move into HI in the same busy window. After idle it checks that HI holds the divide's remainder. Random multiply and divide traffic is mixed with directed corners: the overflowing signed divide, divides by zero, and sign combinations that show truncation toward zero.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] FN_MFHI  = 6'd16;
    localparam logic [5:0] FN_MTHI  = 6'd17;
    localparam logic [5:0] FN_MFLO  = 6'd18;
    localparam logic [5:0] FN_MTLO  = 6'd19;
    localparam logic [5:0] FN_MULT  = 6'd24;
    localparam logic [5:0] FN_MULTU = 6'd25;
    localparam logic [5:0] FN_DIV   = 6'd26;
    localparam logic [5:0] FN_DIVU  = 6'd27;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_SET_HI,
        ACT_SET_LO,
        ACT_MUL,
        ACT_DIV
    } act_e;

    typedef struct packed {
        act_e act;
        logic sgn;
    } cmd_t;

    function automatic cmd_t decode_funct(input logic [5:0] f);
        cmd_t c;
        c.act = ACT_NONE;
        c.sgn = 1'b0;
        case (f)
            FN_MTHI:  c.act = ACT_SET_HI;
            FN_MTLO:  c.act = ACT_SET_LO;
            FN_MULT:  begin c.act = ACT_MUL; c.sgn = 1'b1; end
            FN_MULTU: c.act = ACT_MUL;
            FN_DIV:   begin c.act = ACT_DIV; c.sgn = 1'b1; end
            FN_DIVU:  c.act = ACT_DIV;
            FN_MFHI, FN_MFLO: c.act = ACT_NONE;
            default:  c.act = ACT_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hilo_mult.sv
module hilo_mult #(
    parameter int W = hilo_pkg::XLEN
) (
    input  logic           sgn,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [PW-1:0] ext_a;
    logic [PW-1:0] ext_b;

    always_comb begin
        ext_a = {{W{sgn & a[W-1]}}, a};
        ext_b = {{W{sgn & b[W-1]}}, b};
        prod  = ext_a * ext_b;
    end
endmodule

// File: rtl/hilo_div.sv
module hilo_div #(
    parameter int W = hilo_pkg::XLEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic         sgn,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  rem_q, quo_q, dvs_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q, neg_quo_q, neg_rem_q;

    logic [W:0]    shifted, diff;
    logic          fits;
    logic [W-1:0]  rem_nx, quo_nx;

    function automatic logic [W-1:0] magnitude(input logic [W-1:0] x, input logic s);
        return (s && x[W-1]) ? (~x + 1'b1) : x;
    endfunction

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        diff    = shifted - {1'b0, dvs_q};
        fits    = ~diff[W];
        rem_nx  = fits ? diff[W-1:0] : shifted[W-1:0];
        quo_nx  = {quo_q[W-2:0], fits};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            cnt_q     <= '0;
            rem_q     <= '0;
            quo_q     <= '0;
            dvs_q     <= '0;
            neg_quo_q <= 1'b0;
            neg_rem_q <= 1'b0;
        end else if (busy_q) begin
            rem_q <= rem_nx;
            quo_q <= quo_nx;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) busy_q <= 1'b0;
        end else if (go) begin
            busy_q    <= 1'b1;
            cnt_q     <= '0;
            rem_q     <= '0;
            quo_q     <= magnitude(dividend, sgn);
            dvs_q     <= magnitude(divisor, sgn);
            neg_quo_q <= sgn & (dividend[W-1] ^ divisor[W-1]);
            neg_rem_q <= sgn & dividend[W-1];
        end
    end

    assign busy      = busy_q;
    assign done      = busy_q && (cnt_q == LAST);
    assign quotient  = neg_quo_q ? (~quo_nx + 1'b1) : quo_nx;
    assign remainder = neg_rem_q ? (~rem_nx + 1'b1) : rem_nx;
endmodule

// File: rtl/hilo_unit.sv
module hilo_unit #(
    parameter int W = hilo_pkg::XLEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [5:0]   funct,
    input  logic [W-1:0] rs_val,
    input  logic [W-1:0] rt_val,
    output logic         busy,
    input  logic         rd_req,
    input  logic         rd_hi,
    output logic         rd_valid,
    output logic [W-1:0] rd_data
);
    import hilo_pkg::*;

    cmd_t           cmd;
    logic           accept;
    logic [2*W-1:0] product;
    logic           div_busy, div_done;
    logic [W-1:0]   div_quo, div_rem;
    logic [W-1:0]   hi_q, lo_q;

    assign cmd    = decode_funct(funct);
    assign accept = start && !div_busy;

    hilo_mult #(.W(W)) u_mult (
        .sgn  (cmd.sgn),
        .a    (rs_val),
        .b    (rt_val),
        .prod (product)
    );

    hilo_div #(.W(W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .go        (accept && cmd.act == ACT_DIV),
        .sgn       (cmd.sgn),
        .dividend  (rs_val),
        .divisor   (rt_val),
        .busy      (div_busy),
        .done      (div_done),
        .quotient  (div_quo),
        .remainder (div_rem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (div_done) begin
            hi_q <= div_rem;
            lo_q <= div_quo;
        end else if (accept) begin
            case (cmd.act)
                ACT_SET_HI: hi_q <= rs_val;
                ACT_SET_LO: lo_q <= rs_val;
                ACT_MUL: begin
                    hi_q <= product[2*W-1:W];
                    lo_q <= product[W-1:0];
                end
                default: ;
            endcase
        end
    end

    assign busy     = div_busy;
    assign rd_valid = rd_req && !div_busy;
    assign rd_data  = rd_hi ? hi_q : lo_q;
endmodule

// File: rtl/hilo_unit_sva.sv
module hilo_unit_sva #(
    parameter int W = hilo_pkg::XLEN
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [5:0]   funct,
    input logic [W-1:0] rs_val,
    input logic         busy,
    input logic         rd_valid,
    input logic [W-1:0] hi_q,
    input logic [W-1:0] lo_q
);
    logic [7:0] busy_run;
    logic       idle_start;

    assign idle_start = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else busy_run <= '0;
    end

    a_r6_busy_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> busy_run == 8'(W));

    a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(hi_q) && $stable(lo_q)));

    a_r6_divide_raises_busy: assert property (@(posedge clk) disable iff (rst)
        (idle_start && (funct == 6'd26 || funct == 6'd27)) |=> busy);

    a_r2_multiply_no_busy: assert property (@(posedge clk) disable iff (rst)
        (idle_start && (funct == 6'd24 || funct == 6'd25)) |=> !busy);

    a_r7_write_hi_only: assert property (@(posedge clk) disable iff (rst)
        (idle_start && funct == 6'd17) |=> (hi_q == $past(rs_val) && $stable(lo_q)));

    a_r7_write_lo_only: assert property (@(posedge clk) disable iff (rst)
        (idle_start && funct == 6'd19) |=> (lo_q == $past(rs_val) && $stable(hi_q)));

    a_r8_no_read_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !rd_valid);

    a_r10_read_codes_inert: assert property (@(posedge clk) disable iff (rst)
        (idle_start && (funct == 6'd16 || funct == 6'd18)) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

bind hilo_unit hilo_unit_sva #(.W(W)) u_sva (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .funct    (funct),
    .rs_val   (rs_val),
    .busy     (busy),
    .rd_valid (rd_valid),
    .hi_q     (hi_q),
    .lo_q     (lo_q)
);

// File: tb/sim_hilo_unit.sv
`timescale 1ns/1ps
module sim_hilo_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  funct = '0;
    logic [31:0] rs_val = '0, rt_val = '0;
    logic        busy;
    logic        rd_req = 1'b0, rd_hi = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hilo_unit u0 (
        .clk(clk), .rst(rst), .start(start), .funct(funct),
        .rs_val(rs_val), .rt_val(rt_val), .busy(busy),
        .rd_req(rd_req), .rd_hi(rd_hi), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [63:0] expect_result(input logic [5:0] f, input logic [31:0] a,
                                                  input logic [31:0] b);
        longint sa, sb, q, r;
        logic [63:0] ua, ub, p;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        ua = {32'd0, a};
        ub = {32'd0, b};
        case (f)
            6'd24: begin p = 64'(sa * sb); return p; end
            6'd25: begin p = ua * ub; return p; end
            6'd26: begin q = sa / sb; r = sa % sb; return {r[31:0], q[31:0]}; end
            default: return {32'(ua % ub), 32'(ua / ub)};
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic issue(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        start = 1'b1; funct = f; rs_val = a; rt_val = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
            if (n > 100) break;
        end
    endtask

    task automatic read_reg(input logic sel, output logic [31:0] d, output logic v);
        rd_req = 1'b1; rd_hi = sel;
        #0.5;
        d = rd_data; v = rd_valid;
        rd_req = 1'b0;
    endtask

    task automatic read_both(output logic [63:0] hl);
        logic [31:0] h, l;
        logic v1, v2;
        read_reg(1'b1, h, v1);
        read_reg(1'b0, l, v2);
        hl = {h, l};
    endtask

    task automatic run_op(input string req, input logic [5:0] f, input logic [31:0] a,
                          input logic [31:0] b);
        int n;
        logic [63:0] hl;
        issue(f, a, b);
        wait_idle(n);
        if (f == 6'd26 || f == 6'd27) check("R6 busy cycles", 64'(n), 64'd32);
        else check("R2 multiply leaves busy low", 64'(n), 64'd0);
        read_both(hl);
        check(req, hl, expect_result(f, a, b));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        logic [63:0] hl, hs, hu;
        logic [31:0] d;
        logic v;
        int n;
        seed_dummy = $urandom(32'd4242);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        read_both(hl);
        check("R1 reset HI/LO", hl, 64'd0);
        check("R1 reset busy", 64'(busy), 64'd0);

        // R3 signed vs unsigned HI differ
        issue(6'd24, 32'h12345678, 32'habcdef01); read_both(hs);
        check("R2 signed product", hs, expect_result(6'd24, 32'h12345678, 32'habcdef01));
        issue(6'd25, 32'h12345678, 32'habcdef01); read_both(hu);
        check("R3 unsigned product", hu, expect_result(6'd25, 32'h12345678, 32'habcdef01));
        check("R3 HI differs", 64'(hs[63:32] != hu[63:32]), 64'd1);

        // R4 sign corners
        run_op("R4 -7/2", 6'd26, 32'hFFFFFFF9, 32'd2);
        check("R4 -7/2 direct", {32'hFFFFFFFF, 32'hFFFFFFFD},
              expect_result(6'd26, 32'hFFFFFFF9, 32'd2));
        run_op("R4 7/-2", 6'd26, 32'd7, 32'hFFFFFFFE);
        run_op("R4 overflow", 6'd26, 32'h80000000, 32'hFFFFFFFF);
        read_both(hl);
        check("R4 overflow value", hl, {32'd0, 32'h80000000});
        run_op("R5 unsigned divide", 6'd27, 32'habcdef01, 32'h12345678);

        // R7 single-register writes
        issue(6'd17, 32'hA5A5A5A5, 32'h0); issue(6'd19, 32'h5A5A5A5A, 32'h0);
        read_both(hl);
        check("R7 MTHI/MTLO", hl, {32'hA5A5A5A5, 32'h5A5A5A5A});
        issue(6'd17, 32'h11112222, 32'h0);
        read_both(hl);
        check("R7 MTHI keeps LO", hl, {32'h11112222, 32'h5A5A5A5A});

        // R10 inert codes
        issue(6'd16, 32'hDEADBEEF, 32'h1); issue(6'd18, 32'hDEADBEEF, 32'h1);
        issue(6'd63, 32'hDEADBEEF, 32'h1); issue(6'd0, 32'hDEADBEEF, 32'h1);
        read_both(hl);
        check("R10 unknown codes ignored", hl, {32'h11112222, 32'h5A5A5A5A});

        // R8 read select and valid
        read_reg(1'b1, d, v);
        check("R8 read HI", {31'd0, v, d}, {31'd0, 1'b1, 32'h11112222});

        // R8/R9 read and start during busy
        issue(6'd27, 32'd100, 32'd7);
        read_reg(1'b0, d, v);
        check("R8 valid low while busy", 64'(v), 64'd0);
        check("R6 busy after divide start", 64'(busy), 64'd1);
        issue(6'd17, 32'hCAFEF00D, 32'h0);
        issue(6'd24, 32'd3, 32'd3);
        wait_idle(n);
        read_both(hl);
        check("R9 start while busy ignored", hl, {32'd2, 32'd14});
        read_reg(1'b0, d, v);
        check("R8 valid after idle", 64'(v), 64'd1);

        // R11 divide by zero
        issue(6'd27, 32'h1234, 32'd0); wait_idle(n);
        check("R11 divu by zero cycles", 64'(n), 64'd32);
        issue(6'd26, 32'hFFFF0000, 32'd0); wait_idle(n);
        check("R11 div by zero cycles", 64'(n), 64'd32);
        check("R11 idle after", 64'(busy), 64'd0);

        // Random traffic for R2..R5
        for (int i = 0; i < 160; i++) begin
            logic [5:0] f;
            logic [31:0] a, b;
            f = 6'd24 + 6'($urandom_range(0, 3));
            a = $urandom();
            b = $urandom();
            if ($urandom_range(0, 3) == 0) b = b & 32'h0000000F;
            if (b == 0) b = 32'd1;
            case (f)
                6'd24: run_op("R2 random signed multiply", f, a, b);
                6'd25: run_op("R3 random unsigned multiply", f, a, b);
                6'd26: run_op("R4 random signed divide", f, a, b);
                default: run_op("R5 random unsigned divide", f, a, b);
            endcase
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule